// File: doc/BRIEF.md
# Serial EEPROM Command Slave

This block models the command side of a three-wire serial memory slave. The slave has a chip select, a serial clock, a data input and a data output. A fast system clock samples the three serial inputs through two-flop synchronizers and detects serial clock rising edges in its own domain. Each frame opens with a start bit. An opcode, an address and, for writes, a data field follow. The block decodes three commands: single-word write, single-word erase and bulk erase of the whole array. A command takes effect only if chip select falls in the narrow gap between the last expected bit and the next serial clock rising edge.

An accepted command starts a self-timed programming cycle that runs for a fixed number of system clocks. The register array sits behind a synchronous write port, so block RAM can be inferred. A write first fills the target word with ones and loads the new data when the cycle ends. Bulk erase visits one word per clock while the cycle runs. While chip select is high, the data output shows the cycle state: low means busy and high means ready. Commands that arrive during a cycle are dropped. A parallel read port with one clock of latency exposes the array contents.

Top module: `ser_prom_slave`

## Requirements
- R1: During reset and in the first cycle after reset, `sdo_out` is high. No cycle is running after reset.
- R2: A write frame programs word `addr` with `data` once its cycle completes. The frame is a 1 start bit, then opcode bits 0,1, then ADDR_W address bits MSB first, then DATA_W data bits MSB first.
- R3: An erase frame sets every bit of word `addr` to 1. The frame is a 1 start bit, then opcode bits 1,1, then ADDR_W address bits MSB first.
- R4: A bulk-erase frame sets every bit of every word to 1. The frame is a 1 start bit, then opcode bits 0,0, then 1,0 in the two top address positions. The remaining address bits are ignored.
- R5: If chip select falls before the last bit of a frame has been sampled, no cycle starts and the array is unchanged.
- R6: If a further serial clock rising edge arrives after the last bit while chip select is still high, no cycle starts and the array is unchanged.
- R7: Zeros that are clocked in before the start bit are skipped.
- R8: While chip select is high, `sdo_out` is low for exactly CYCLE_LEN system clocks per accepted command and high otherwise.
- R9: A frame that completes while a cycle is running is dropped and leaves the array unchanged.
- R10: During a write cycle, the target word reads all ones until the cycle ends.
- R11: A cycle completes with the correct result even when the serial clock keeps toggling during it.
- R12: Frames with opcode 1,0, and frames with opcode 0,0 whose top two address bits are not 1,0, start no cycle and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_in | input | 1 | Chip select, active high, asynchronous |
| sck_in | input | 1 | Serial clock, asynchronous |
| sdi_in | input | 1 | Serial data in, captured on serial clock rising edges |
| sdo_out | output | 1 | Ready (1) or busy (0) while selected; high when not selected |
| peek_addr | input | ADDR_W | Array read address |
| peek_data | output | DATA_W | Word at `peek_addr`, one clock later |

## Verification
The bench builds the block with ADDR_W=4, DATA_W=8 and CYCLE_LEN=150. The array is then 16 words deep, so both bulk-erase passes can read back every word. The 8-bit organization keeps write frames at 15 bits. A cycle of 150 clocks is longer than a whole serial erase frame sent at eight system clocks per bit. A complete command can therefore be clocked in during a running cycle, which makes the drop-while-busy and clock-keeps-running cases reachable.

// File: rtl/ser_prom_pkg.sv
package ser_prom_pkg;
  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_ERASE = 2'b11;
  localparam logic [1:0] EXT_BULK = 2'b10;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_WRITE,
    CMD_ERASE,
    CMD_BULK
  } cmd_e;

  typedef enum logic [1:0] {
    F_HUNT,
    F_SHIFT,
    F_ARMED,
    F_DEAD
  } frame_st_e;
endpackage

// File: rtl/ser_prom_sync.sv
module ser_prom_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d_in[i];
        stab_q <= meta_q;
      end
    end
    assign d_out[i] = stab_q;
  end
endmodule

// File: rtl/ser_prom_frame.sv
module ser_prom_frame
  import ser_prom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  output logic              cmd_vld,
  output cmd_e              cmd,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);
  localparam int HDR  = 2 + ADDR_W;
  localparam int FULL = HDR + DATA_W;
  localparam int CW   = $clog2(FULL + 1);
  localparam logic [CW-1:0] OP_LAST  = CW'(1);
  localparam logic [CW-1:0] HDR_LAST = CW'(HDR - 1);
  localparam logic [CW-1:0] ALL_LAST = CW'(FULL - 1);

  frame_st_e         state;
  logic [CW-1:0]     cnt;
  logic [1:0]        op;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic              sck_q, cs_q;
  logic              sck_rise, cs_fall;
  cmd_e              dec;

  assign sck_rise = sck_s & ~sck_q;
  assign cs_fall  = cs_q & ~cs_s;

  always_comb begin
    if (op == OP_WRITE)
      dec = CMD_WRITE;
    else if (op == OP_ERASE)
      dec = CMD_ERASE;
    else if (op == OP_EXT && addr[ADDR_W-1 -: 2] == EXT_BULK)
      dec = CMD_BULK;
    else
      dec = CMD_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= F_HUNT;
      cnt      <= '0;
      op       <= '0;
      addr     <= '0;
      data     <= '0;
      sck_q    <= 1'b0;
      cs_q     <= 1'b0;
      cmd_vld  <= 1'b0;
      cmd      <= CMD_NONE;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      sck_q   <= sck_s;
      cs_q    <= cs_s;
      cmd_vld <= 1'b0;
      if (!cs_s) begin
        // deselect: commit only from the armed window, else abort
        state <= F_HUNT;
        cnt   <= '0;
        if (cs_fall && state == F_ARMED) begin
          cmd_vld  <= 1'b1;
          cmd      <= dec;
          cmd_addr <= addr;
          cmd_data <= data;
        end
      end else if (sck_rise) begin
        case (state)
          F_HUNT: begin
            if (sdi_s) begin
              state <= F_SHIFT;
              cnt   <= '0;
            end
          end
          F_SHIFT: begin
            cnt <= cnt + 1'b1;
            if (cnt <= OP_LAST)
              op <= {op[0], sdi_s};
            else if (cnt <= HDR_LAST)
              addr <= {addr[ADDR_W-2:0], sdi_s};
            else
              data <= {data[DATA_W-2:0], sdi_s};
            if ((cnt == HDR_LAST && op != OP_WRITE) || cnt == ALL_LAST)
              state <= F_ARMED;
          end
          F_ARMED: state <= F_DEAD;
          default: state <= F_DEAD;
        endcase
      end
    end
  end
endmodule

// File: rtl/ser_prom_ctrl.sv
module ser_prom_ctrl
  import ser_prom_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int CYCLE_LEN = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_vld,
  input  cmd_e              cmd,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wd
);
  localparam int TW = $clog2(CYCLE_LEN + 1);
  localparam logic [TW-1:0] T_LOAD = TW'(CYCLE_LEN - 1);

  logic [TW-1:0]     timer;
  logic              pend_write;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic              sweep_on;
  logic [ADDR_W-1:0] sweep_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      timer      <= '0;
      pend_write <= 1'b0;
      pend_addr  <= '0;
      pend_data  <= '0;
      sweep_on   <= 1'b0;
      sweep_addr <= '0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wd     <= '0;
    end else begin
      mem_we <= 1'b0;
      if (!busy) begin
        if (cmd_vld && cmd != CMD_NONE) begin
          busy       <= 1'b1;
          timer      <= T_LOAD;
          pend_write <= (cmd == CMD_WRITE);
          pend_addr  <= cmd_addr;
          pend_data  <= cmd_data;
          mem_we     <= 1'b1;
          mem_wd     <= '1;
          if (cmd == CMD_BULK) begin
            sweep_on   <= 1'b1;
            sweep_addr <= ADDR_W'(1);
            mem_addr   <= '0;
          end else begin
            mem_addr <= cmd_addr;
          end
        end
      end else begin
        if (sweep_on) begin
          mem_we     <= 1'b1;
          mem_addr   <= sweep_addr;
          mem_wd     <= '1;
          sweep_addr <= sweep_addr + 1'b1;
          if (sweep_addr == '1)
            sweep_on <= 1'b0;
        end
        if (timer == '0) begin
          busy <= 1'b0;
          if (pend_write) begin
            mem_we   <= 1'b1;
            mem_addr <= pend_addr;
            mem_wd   <= pend_data;
          end
        end else begin
          timer <= timer - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ser_prom_mem.sv
module ser_prom_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ser_prom_slave.sv
module ser_prom_slave
  import ser_prom_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int CYCLE_LEN = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_in,
  input  logic              sck_in,
  input  logic              sdi_in,
  output logic              sdo_out,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [DATA_W-1:0] peek_data
);
  logic              cs_s, sck_s, sdi_s;
  logic              cmd_vld;
  cmd_e              cmd;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  logic              busy;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wd;

  ser_prom_sync #(.W(3)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  ({cs_in, sck_in, sdi_in}),
    .d_out ({cs_s, sck_s, sdi_s})
  );

  ser_prom_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .cs_s     (cs_s),
    .sck_s    (sck_s),
    .sdi_s    (sdi_s),
    .cmd_vld  (cmd_vld),
    .cmd      (cmd),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data)
  );

  ser_prom_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYCLE_LEN(CYCLE_LEN)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmd_vld  (cmd_vld),
    .cmd      (cmd),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data),
    .busy     (busy),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wd   (mem_wd)
  );

  ser_prom_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_wd),
    .raddr (peek_addr),
    .rdata (peek_data)
  );

  always_ff @(posedge clk) begin
    if (rst)
      sdo_out <= 1'b1;
    else
      sdo_out <= cs_s ? ~busy : 1'b1;
  end
endmodule

// File: rtl/ser_prom_slave_chk.sv
module ser_prom_slave_chk #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int CYCLE_LEN = 100
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wd,
  input logic              sdo_out
);
  int run;

  always_ff @(posedge clk) begin
    if (rst || !busy)
      run <= 0;
    else
      run <= run + 1;
  end

  // R1
  reset_sdo_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> sdo_out);

  // R8 (a restart while busy, against R9, would also stretch this)
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(run) == CYCLE_LEN - 1);

  // R8
  busy_cap_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> run < CYCLE_LEN);

  // R10
  erase_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (mem_we && mem_wd == '1));

  // R4
  sweep_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && mem_we && $past(mem_we) && mem_wd == '1 && $past(mem_wd) == '1)
      |-> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));
endmodule

bind ser_prom_slave ser_prom_slave_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYCLE_LEN(CYCLE_LEN)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wd   (mem_wd),
  .sdo_out  (sdo_out)
);

// File: tb/tb_ser_prom_slave.sv
module tb_ser_prom_slave;
  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int CYC = 150;
  localparam int NW  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_in = 1'b0, sck_in = 1'b0, sdi_in = 1'b0;
  logic          sdo_out;
  logic [AW-1:0] peek_addr = '0;
  logic [DW-1:0] peek_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ser_prom_slave #(.ADDR_W(AW), .DATA_W(DW), .CYCLE_LEN(CYC)) dut (
    .clk(clk), .rst(rst), .cs_in(cs_in), .sck_in(sck_in), .sdi_in(sdi_in),
    .sdo_out(sdo_out), .peek_addr(peek_addr), .peek_data(peek_data)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    sdi_in = b;
    tick(4);
    sck_in = 1'b1;
    tick(4);
    sck_in = 1'b0;
  endtask

  // mode 0: normal, 1: early deselect, 2: late deselect, 3: normal with short select pulse
  task automatic frame(input logic [31:0] v, input int n, input int zeros, input int mode);
    cs_in = 1'b1;
    tick(3);
    for (int i = 0; i < zeros; i++) sbit(1'b0);
    for (int i = n - 1; i >= (mode == 1 ? 1 : 0); i--) sbit(v[i]);
    if (mode == 2) sbit(1'b0);
    tick(1);
    cs_in = 1'b0;
    if (mode == 3) begin
      tick(1);
      cs_in = 1'b1;
    end else begin
      tick(4);
    end
  endtask

  function automatic logic [31:0] wr_bits(input logic [AW-1:0] a, input logic [DW-1:0] d);
    return 32'({3'b101, a, d});
  endfunction

  function automatic logic [31:0] er_bits(input logic [AW-1:0] a);
    return 32'({3'b111, a});
  endfunction

  task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] d);
    peek_addr = a;
    tick(3);
    d = peek_data;
  endtask

  task automatic wait_cycle;
    tick(CYC + 30);
  endtask

  task automatic expect_word(input string rq, input logic [AW-1:0] a, input logic [DW-1:0] e);
    logic [DW-1:0] d;
    peek(a, d);
    chk(rq, 32'(d), 32'(e));
  endtask

  task automatic t_reset;
    chk("R1 sdo in reset", 32'(sdo_out), 32'd1);
    rst = 1'b0;
    tick(1);
    chk("R1 sdo after reset", 32'(sdo_out), 32'd1);
    cs_in = 1'b1;
    tick(5);
    chk("R1 ready when selected", 32'(sdo_out), 32'd1);
    cs_in = 1'b0;
    tick(3);
  endtask

  task automatic t_bulk(input string rq);
    frame(32'b1_00_10_11, 7, 0, 0);
    wait_cycle();
    for (int a = 0; a < NW; a++) expect_word(rq, AW'(a), '1);
  endtask

  task automatic t_write;
    frame(wr_bits(4'd3, 8'h5A), 15, 0, 0);
    wait_cycle();
    frame(wr_bits(4'd9, 8'hC3), 15, 0, 0);
    wait_cycle();
    expect_word("R2 write a3", 4'd3, 8'h5A);
    expect_word("R2 write a9", 4'd9, 8'hC3);
    expect_word("R2 neighbour a4", 4'd4, 8'hFF);
  endtask

  task automatic t_erase;
    frame(er_bits(4'd3), 7, 0, 0);
    wait_cycle();
    expect_word("R3 erased a3", 4'd3, 8'hFF);
    expect_word("R3 untouched a9", 4'd9, 8'hC3);
  endtask

  task automatic t_window;
    frame(wr_bits(4'd5, 8'h12), 15, 0, 1);
    wait_cycle();
    expect_word("R5 early deselect", 4'd5, 8'hFF);
    frame(wr_bits(4'd6, 8'h34), 15, 0, 2);
    wait_cycle();
    expect_word("R6 late deselect", 4'd6, 8'hFF);
  endtask

  task automatic t_zeros;
    frame(wr_bits(4'd7, 8'h77), 15, 3, 0);
    wait_cycle();
    expect_word("R7 leading zeros", 4'd7, 8'h77);
  endtask

  task automatic t_timing;
    int  low;
    bit  seen;
    peek_addr = 4'd10;
    frame(wr_bits(4'd10, 8'hA5), 15, 0, 3);
    low  = 0;
    seen = 1'b0;
    for (int i = 0; i < 3 * CYC + 50; i++) begin
      tick(1);
      if (!sdo_out) begin
        low++;
        seen = 1'b1;
        if (low == CYC / 2) chk("R10 word erased mid-cycle", 32'(peek_data), 32'hFF);
      end else if (seen) begin
        break;
      end
    end
    chk("R8 busy length", 32'(low), 32'(CYC));
    chk("R8 ready after cycle", 32'(sdo_out), 32'd1);
    cs_in = 1'b0;
    tick(4);
    expect_word("R2 write a10", 4'd10, 8'hA5);
  endtask

  task automatic t_busy;
    frame(wr_bits(4'd11, 8'h11), 15, 0, 0);
    frame(er_bits(4'd7), 7, 0, 0);
    wait_cycle();
    expect_word("R9 dropped erase a7", 4'd7, 8'h77);
    expect_word("R11 write with sck running a11", 4'd11, 8'h11);
  endtask

  task automatic t_other;
    frame(32'({3'b110, 4'd9}), 7, 0, 3);
    tick(10);
    chk("R12 read opcode no busy", 32'(sdo_out), 32'd1);
    cs_in = 1'b0;
    tick(4);
    frame(32'({3'b100, 4'b0011}), 7, 0, 3);
    tick(10);
    chk("R12 plain ext opcode no busy", 32'(sdo_out), 32'd1);
    cs_in = 1'b0;
    tick(4);
    expect_word("R12 a9 unchanged", 4'd9, 8'hC3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(5);
    t_reset();
    t_bulk("R4 first bulk erase");
    t_write();
    t_erase();
    t_window();
    t_zeros();
    t_timing();
    t_busy();
    t_other();
    t_bulk("R4 bulk erase over data");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule